// File: doc/BRIEF.md
# Binary BCH Error-Locator Solver

This block takes the syndromes of a binary BCH codeword over GF(2^13) and derives the error-locator polynomial sigma(x) and its degree. It uses the binary simplification of the Berlekamp iteration: each iteration adds two to the order of the step counter. A decoder loads the syndromes, chooses a correction strength t for the current sector, and pulses `start`. When `done` rises, the coefficients of sigma(x) and the number of located errors are on the outputs and stay there until the next start. A later root search uses those coefficients.

The solver keeps a table of rows. Each row holds a candidate polynomial, its discrepancy, its degree L and a delta value equal to the step order minus L. For a nonzero discrepancy, the new polynomial is formed from the current row and the scaled, shifted polynomial of an earlier reference row. The reference row is the earlier row with a nonzero discrepancy and the largest delta. The scale factor is a quotient of discrepancies. It is formed as a product with a field inverse, and that inverse is found by raising the divisor to the power 8190 over twelve clock cycles. The solver keeps a running count of zero discrepancies. It stops early once this count equals a limit derived from t and the current degree.

The control is a single state machine:
- **IDLE** and **DONE** wait for `start` and then go to **INIT**.
- **INIT** seeds the two starting rows and goes to **CHECK**.
- **CHECK** examines the discrepancy of the current row:
  - if it is zero, it goes to **FINISH** when the zero-count limit is hit, and to **NEXTD** otherwise;
  - if it is nonzero, it goes to **INVERT**.
- **INVERT** waits for the inverse and then goes to **SCALE**.
- **SCALE** goes to **UPDATE**, and **UPDATE** goes to **NEXTD**.
- **NEXTD** goes to **FINISH** after iteration t; otherwise it computes the next discrepancy and returns to **CHECK**.
- **FINISH** latches the outputs and goes to **DONE**.

Top module: `bch_bm_solver`

## Requirements
- R1: While reset is asserted and immediately after it, `done` is 0, `degree` is 0 and every `sigma` coefficient is 0.
- R2: When all syndromes are zero, the result is sigma(x) = 1 with degree 0. In every result, coefficient 0 of `sigma` equals 1.
- R3: Field elements use the primitive polynomial x^13+x^4+x^3+x+1, with alpha = 2. Syndrome S_j is placed at `syn` index j-1, with S_j = XOR over errors of alpha^(j*p). For one error at position p, with t >= 1, the result is sigma = 1 + alpha^p x with degree 1. The constant coefficient is at `sigma` index 0.
- R4: For v distinct error positions p_1..p_v with v <= t, the result is the product over e of (1 + alpha^(p_e) x), with degree v.
- R5: A `t_sel` of 0 is treated as t = 1, and a value above TMAX is treated as TMAX. Syndrome entries at `syn` index 2t and above do not affect the result.
- R6: The count of zero discrepancies is never reset during a run. On a zero discrepancy at iteration i with current degree L, let g = t - L - 1. The limit is g/2 + 2 if g is odd and g/2 + 1 if g is even, and there is no limit if g < 0. When the count equals the limit, the solver stops. With all syndromes zero, `done` is first seen high 4, 6 and 8 clock edges after the edge that samples `start`, for t = 1, 3 and 4 respectively.
- R7: A `start` pulse while a run is in progress is ignored: the result and the completion cycle are unchanged.
- R8: `done` stays high, and `sigma` and `degree` hold, until the next `start`, which clears `done` on the following edge.
- R9: On a result, every `sigma` coefficient above `degree` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a solve; sampled in IDLE and DONE only |
| t_sel | input | TW | Correction strength t for this run |
| syn | input | 2*TMAX x M | Syndromes S_1..S_2TMAX; must be held until `done` |
| sigma | output | (TMAX+1) x M | Locator coefficients, constant term at index 0 |
| degree | output | LW | Degree of sigma (number of errors located) |
| done | output | 1 | Result valid; held until next start |

## Verification
A wrong discrepancy, a wrong reference-row choice or a wrong scale factor in any iteration corrupts a row that later rows build on. At the `done` edge this shows as a coefficient that no longer matches the product over the injected error positions, or as a degree that differs from the error count. A fault in the zero-discrepancy count or in its limit moves the `done` edge by whole iterations, two clock edges each on the zero-discrepancy path. The bench therefore compares completion cycles for several values of t, as well as the polynomials themselves.

// File: rtl/bch_bm_pkg.sv
package bch_bm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_INIT,
        ST_CHECK,
        ST_INVERT,
        ST_SCALE,
        ST_UPDATE,
        ST_NEXTD,
        ST_FINISH,
        ST_DONE
    } bm_state_e;

    // Step order of a table row: row 0 is the seed row at order -1.
    function automatic int row_mu(input int r);
        return (r == 0) ? -1 : 2 * (r - 1);
    endfunction

    // Number of zero discrepancies after which the solver may stop.
    function automatic int zero_run_limit(input int t, input int l);
        int g;
        g = t - l - 1;
        if (g < 0) return -1;
        return g / 2 + (((g % 2) != 0) ? 2 : 1);
    endfunction

endpackage

// File: rtl/bch_gf_mul.sv
module bch_gf_mul #(
    parameter int M    = 13,
    parameter int POLY = 'h201B
) (
    input  logic [M-1:0] a,
    input  logic [M-1:0] b,
    output logic [M-1:0] p
);
    localparam logic [M-1:0] RED = M'(POLY);

    logic [M-1:0] acc;
    logic [M-1:0] sh;

    always_comb begin
        acc = '0;
        sh  = a;
        for (int k = 0; k < M; k++) begin
            if (b[k]) acc = acc ^ sh;
            sh = sh[M-1] ? ((sh << 1) ^ RED) : (sh << 1);
        end
        p = acc;
    end
endmodule

// File: rtl/bch_gf_inv.sv
module bch_gf_inv #(
    parameter int M    = 13,
    parameter int POLY = 'h201B
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [M-1:0] op,
    output logic [M-1:0] inv,
    output logic         rdy
);
    localparam int CW = $clog2(M);

    logic [M-1:0]  base_q;
    logic [M-1:0]  acc_q;
    logic [M-1:0]  op_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [M-1:0]  base_sq;
    logic [M-1:0]  acc_nx;
    logic [M-1:0]  chk;

    bch_gf_mul #(.M(M), .POLY(POLY)) u_sq  (.a(base_q), .b(base_q), .p(base_sq));
    bch_gf_mul #(.M(M), .POLY(POLY)) u_acc (.a(acc_q),  .b(base_sq), .p(acc_nx));
    bch_gf_mul #(.M(M), .POLY(POLY)) u_chk (.a(op_q),   .b(acc_q),  .p(chk));

    // op^(2^M-2) = product of op^(2^j) for j = 1 .. M-1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            acc_q  <= '0;
            op_q   <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            rdy    <= 1'b0;
        end else if (go) begin
            base_q <= op;
            op_q   <= op;
            acc_q  <= M'(1);
            cnt_q  <= CW'(M - 1);
            run_q  <= 1'b1;
            rdy    <= 1'b0;
        end else if (run_q) begin
            base_q <= base_sq;
            acc_q  <= acc_nx;
            cnt_q  <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
                run_q <= 1'b0;
                rdy   <= 1'b1;
            end
        end else begin
            rdy <= 1'b0;
        end
    end

    assign inv = acc_q;

    // The quotient d_i / d_rho relies on this inverse (R4)
    assert_inverse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && (op_q != '0)) |-> (chk == M'(1)));
endmodule

// File: rtl/bch_bm_rho_pick.sv
module bch_bm_rho_pick #(
    parameter int ROWS = 6,
    parameter int RW   = 3,
    parameter int DW   = 6
) (
    input  logic [ROWS-1:0]         live,
    input  logic [ROWS-1:0][DW-1:0] dlt,
    input  logic [RW-1:0]           below,
    output logic [RW-1:0]           rho
);
    logic signed [DW-1:0] best;

    // Earliest row wins a tie: strict comparison.
    always_comb begin
        best = '1;
        rho  = '0;
        for (int j = 0; j < ROWS; j++) begin
            if ((j < int'(below)) && live[j] && ($signed(dlt[j]) > best)) begin
                best = $signed(dlt[j]);
                rho  = RW'(j);
            end
        end
    end
endmodule

// File: rtl/bch_bm_solver.sv
module bch_bm_solver import bch_bm_pkg::*; #(
    parameter  int M    = 13,
    parameter  int TMAX = 4,
    parameter  int POLY = 'h201B,
    localparam int TW   = $clog2(TMAX + 1),
    localparam int LW   = $clog2(4 * TMAX + 2)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [TW-1:0]                t_sel,
    input  logic [2*TMAX-1:0][M-1:0]     syn,
    output logic [TMAX:0][M-1:0]         sigma,
    output logic [LW-1:0]                degree,
    output logic                         done
);
    localparam int NC   = 2 * TMAX + 1;
    localparam int ROWS = TMAX + 2;
    localparam int RW   = $clog2(ROWS + 1);
    localparam int DW   = LW + 1;
    localparam int NS   = 2 * TMAX;

    bm_state_e st_q, st_d;

    logic [NC-1:0][M-1:0] poly_q [0:ROWS-1];
    logic [M-1:0]         disc_q [0:ROWS-1];
    logic [LW-1:0]        len_q  [0:ROWS-1];
    logic [DW-1:0]        dlt_q  [0:ROWS-1];

    logic [RW-1:0] row_q, rho_q, fin_q, zcnt_q;
    logic [TW-1:0] t_q;
    logic [M-1:0]  fac_q;

    logic [RW-1:0] nxt, nxt_s, rho_c;
    int            row_c, diff_c, nl_c;
    logic [TW-1:0] t_eff;
    logic [M-1:0]  d_cur, inv_val, fac_c, d_next;
    logic          d_zero, stop_hit, last_row, inv_rdy, inv_go;
    logic [NC-1:0][M-1:0] cur_poly, rho_poly, nxt_poly, upd_poly, sc_prod, dprod;
    logic [NC-1:0][M-1:0] s_sel;
    logic [ROWS-1:0]         live_pk;
    logic [ROWS-1:0][DW-1:0] dlt_pk;
    logic [LW-1:0] new_len;

    // ---------------- run configuration ----------------
    always_comb begin
        if (t_sel == '0)                t_eff = TW'(1);
        else if (int'(t_sel) > TMAX)    t_eff = TW'(TMAX);
        else                            t_eff = t_sel;
    end

    assign row_c    = int'(row_q);
    assign nxt      = row_q + 1'b1;
    assign nxt_s    = (int'(nxt) < ROWS) ? nxt : RW'(ROWS - 1);
    assign cur_poly = poly_q[row_q];
    assign rho_poly = poly_q[rho_q];
    assign nxt_poly = poly_q[nxt_s];
    assign d_cur    = disc_q[row_q];
    assign d_zero   = (d_cur == '0);
    assign last_row = (row_c == int'(t_q));
    assign stop_hit = (zero_run_limit(int'(t_q), int'(len_q[row_q])) == int'(zcnt_q) + 1);

    // ---------------- reference row choice ----------------
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            live_pk[r] = |disc_q[r];
            dlt_pk[r]  = dlt_q[r];
        end
    end

    bch_bm_rho_pick #(.ROWS(ROWS), .RW(RW), .DW(DW)) u_pick (
        .live (live_pk),
        .dlt  (dlt_pk),
        .below(row_q),
        .rho  (rho_c)
    );

    // ---------------- divisor inverse and scale ----------------
    assign inv_go = (st_q == ST_CHECK) && !d_zero;

    bch_gf_inv #(.M(M), .POLY(POLY)) u_inv (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (inv_go),
        .op   (disc_q[rho_c]),
        .inv  (inv_val),
        .rdy  (inv_rdy)
    );

    bch_gf_mul #(.M(M), .POLY(POLY)) u_fac (.a(d_cur), .b(inv_val), .p(fac_c));

    // ---------------- polynomial update ----------------
    for (genvar k = 0; k < NC; k++) begin : g_scale
        bch_gf_mul #(.M(M), .POLY(POLY)) u_sc (.a(fac_q), .b(rho_poly[k]), .p(sc_prod[k]));
    end

    assign diff_c = row_mu(row_c) - row_mu(int'(rho_q));

    always_comb begin
        for (int k = 0; k < NC; k++) begin
            upd_poly[k] = cur_poly[k];
            if ((k >= diff_c) && (k - diff_c < NC))
                upd_poly[k] = cur_poly[k] ^ sc_prod[k - diff_c];
        end
        nl_c = int'(len_q[rho_q]) + diff_c;
        if (int'(len_q[row_q]) > nl_c) nl_c = int'(len_q[row_q]);
        if (nl_c > NC - 1)             nl_c = NC - 1;
        new_len = LW'(nl_c);
    end

    // ---------------- next discrepancy ----------------
    always_comb begin
        for (int k = 0; k < NC; k++) begin
            if ((k >= 1) && (2 * row_c - k >= 0) && (2 * row_c - k < NS))
                s_sel[k] = syn[2 * row_c - k];
            else
                s_sel[k] = '0;
        end
    end

    for (genvar k = 0; k < NC; k++) begin : g_disc
        bch_gf_mul #(.M(M), .POLY(POLY)) u_dm (.a(nxt_poly[k]), .b(s_sel[k]), .p(dprod[k]));
    end

    always_comb begin
        d_next = (2 * row_c < NS) ? syn[2 * row_c] : '0;
        for (int k = 1; k < NC; k++) begin
            if (k <= int'(len_q[nxt_s])) d_next = d_next ^ dprod[k];
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE, ST_DONE: if (start) st_d = ST_INIT;
            ST_INIT:          st_d = ST_CHECK;
            ST_CHECK:         st_d = d_zero ? (stop_hit ? ST_FINISH : ST_NEXTD) : ST_INVERT;
            ST_INVERT:        if (inv_rdy) st_d = ST_SCALE;
            ST_SCALE:         st_d = ST_UPDATE;
            ST_UPDATE:        st_d = ST_NEXTD;
            ST_NEXTD:         st_d = last_row ? ST_FINISH : ST_CHECK;
            ST_FINISH:        st_d = ST_DONE;
            default:          st_d = ST_IDLE;
        endcase
    end

    // ---------------- row table and outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                poly_q[r] <= '0;
                disc_q[r] <= '0;
                len_q[r]  <= '0;
                dlt_q[r]  <= '0;
            end
            row_q  <= '0;
            rho_q  <= '0;
            fin_q  <= '0;
            zcnt_q <= '0;
            t_q    <= '0;
            fac_q  <= '0;
            sigma  <= '0;
            degree <= '0;
            done   <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        t_q  <= t_eff;
                        done <= 1'b0;
                    end
                end
                ST_INIT: begin
                    for (int r = 0; r < ROWS; r++) begin
                        poly_q[r] <= '0;
                        disc_q[r] <= '0;
                        len_q[r]  <= '0;
                        dlt_q[r]  <= '0;
                    end
                    poly_q[0][0] <= M'(1);
                    disc_q[0]    <= M'(1);
                    dlt_q[0]     <= '1;
                    poly_q[1][0] <= M'(1);
                    disc_q[1]    <= syn[0];
                    row_q        <= RW'(1);
                    zcnt_q       <= '0;
                end
                ST_CHECK: begin
                    if (d_zero) begin
                        zcnt_q <= zcnt_q + 1'b1;
                        if (stop_hit) begin
                            fin_q <= row_q;
                        end else begin
                            poly_q[nxt_s] <= cur_poly;
                            len_q[nxt_s]  <= len_q[row_q];
                            dlt_q[nxt_s]  <= DW'(2 * row_c - int'(len_q[row_q]));
                        end
                    end else begin
                        rho_q <= rho_c;
                    end
                end
                ST_INVERT: ;
                ST_SCALE:  fac_q <= fac_c;
                ST_UPDATE: begin
                    poly_q[nxt_s] <= upd_poly;
                    len_q[nxt_s]  <= new_len;
                    dlt_q[nxt_s]  <= DW'(2 * row_c - int'(new_len));
                end
                ST_NEXTD: begin
                    if (last_row) begin
                        fin_q <= nxt_s;
                    end else begin
                        disc_q[nxt_s] <= d_next;
                        row_q         <= nxt_s;
                    end
                end
                ST_FINISH: begin
                    sigma  <= poly_q[fin_q][TMAX:0];
                    degree <= len_q[fin_q];
                    done   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(sigma) && $stable(degree)));

    assert_const_term_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (sigma[0] == M'(1)));

    assert_busy_keeps_t_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q != ST_IDLE) && (st_q != ST_DONE)) |=> $stable(t_q));

    assert_t_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CHECK) |-> ((int'(t_q) >= 1) && (int'(t_q) <= TMAX)));

    for (genvar j = 1; j <= TMAX; j++) begin : g_upper
        assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (done && (int'(degree) < j)) |-> (sigma[j] == '0));
    end
endmodule

// File: tb/bch_bm_solver_test.sv
module bch_bm_solver_test;
    localparam int M    = 13;
    localparam int TMAX = 4;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int LW   = $clog2(4 * TMAX + 2);
    localparam int NQ   = 8191;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     start = 1'b0;
    logic [TW-1:0]            t_sel = '0;
    logic [2*TMAX-1:0][M-1:0] syn = '0;
    logic [TMAX:0][M-1:0]     sigma;
    logic [LW-1:0]            degree;
    logic                     done;

    int n_chk = 0;
    int n_err = 0;
    int epos [TMAX];
    logic [M-1:0] expc [0:TMAX];

    bch_bm_solver #(.M(M), .TMAX(TMAX)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .t_sel(t_sel),
        .syn(syn), .sigma(sigma), .degree(degree), .done(done)
    );

    always #2 clk = ~clk;

    function automatic logic [M-1:0] fmul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] r, x;
        r = '0;
        x = a;
        for (int k = 0; k < M; k++) begin
            if (b[k]) r = r ^ x;
            x = x[M-1] ? ((x << 1) ^ 13'h001B) : (x << 1);
        end
        return r;
    endfunction

    function automatic logic [M-1:0] apow(input int e);
        logic [M-1:0] r, b;
        int n;
        r = 13'd1;
        b = 13'd2;
        n = e % NQ;
        while (n > 0) begin
            if (n % 2 == 1) r = fmul(r, b);
            b = fmul(b, b);
            n = n / 2;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic load_errors(input int nerr);
        logic [M-1:0] s, ap;
        for (int j = 1; j <= 2 * TMAX; j++) begin
            s = '0;
            for (int e = 0; e < nerr; e++) s = s ^ apow(j * epos[e]);
            syn[j-1] = s;
        end
        for (int k = 0; k <= TMAX; k++) expc[k] = (k == 0) ? 13'd1 : 13'd0;
        for (int e = 0; e < nerr; e++) begin
            ap = apow(epos[e]);
            for (int k = TMAX; k >= 1; k--) expc[k] = expc[k] ^ fmul(expc[k-1], ap);
        end
    endtask

    task automatic run(input int tv, output int cyc);
        @(negedge clk);
        t_sel = TW'(tv);
        start = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
        end while (!done && cyc < 400);
    endtask

    task automatic check_result(input string req, input int nerr);
        for (int k = 0; k <= TMAX; k++)
            check(sigma[k] == expc[k], (k > nerr) ? "R9" : req, $sformatf("sigma[%0d]", k),
                  int'(sigma[k]), int'(expc[k]));
        check(int'(degree) == nerr, req, "degree", int'(degree), nerr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1", "done in reset", int'(done), 0);
        check(degree == '0 && sigma == '0, "R1", "outputs in reset", int'(degree), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && sigma == '0, "R1", "done after reset", int'(done), 0);

        // Zero syndromes: early-stop timing per t
        load_errors(0);
        run(4, cyc);
        check(cyc == 8, "R6", "done edge t=4", cyc, 8);
        check_result("R2", 0);
        run(3, cyc);
        check(cyc == 6, "R6", "done edge t=3", cyc, 6);
        check_result("R2", 0);
        run(0, cyc);
        check(cyc == 4, "R5", "done edge t_sel=0", cyc, 4);
        run(7, cyc);
        check(cyc == 8, "R5", "done edge t_sel=7", cyc, 8);
        check_result("R2", 0);

        // Done holds until the next start
        for (int h = 0; h < 4; h++) begin
            @(negedge clk);
            check(done == 1'b1 && sigma[0] == 13'd1, "R8", "held result", int'(done), 1);
        end

        // Start pulses during a run are ignored
        @(negedge clk);
        t_sel = TW'(4);
        start = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            start = (cyc == 3);
        end while (!done && cyc < 400);
        check(cyc == 8, "R7", "done edge with busy start", cyc, 8);
        check_result("R7", 0);

        // Sweep of strengths, error counts and positions
        for (int tv = 1; tv <= TMAX; tv++) begin
            for (int nerr = 0; nerr <= tv; nerr++) begin
                for (int rep = 0; rep < 6; rep++) begin
                    if (nerr == 0 && rep > 0) continue;
                    for (int e = 0; e < TMAX; e++) begin
                        if (rep == 0)      epos[e] = e;
                        else if (rep == 1) epos[e] = NQ - 1 - e;
                        else               epos[e] = (rep * 997 + e * 1234 + tv * 31) % NQ;
                    end
                    load_errors(nerr);
                    run(tv, cyc);
                    check(done == 1'b1, "R4", "done reached", int'(done), 1);
                    check_result((nerr == 0) ? "R2" : ((nerr == 1) ? "R3" : "R4"), nerr);
                end
            end
        end

        // Syndromes at index 2t and above have no effect
        epos[0] = 77;
        epos[1] = 5000;
        load_errors(2);
        for (int j = 4; j < 2 * TMAX; j++) syn[j] = M'(j * 1111 + 5);
        run(2, cyc);
        check_result("R5", 2);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule